// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Core

This block models the device side of a synchronous SRAM that has a read data port and a separate write data port, so data never has to turn around on a shared bus. One address bus serves both ports by time sharing. After reset the cycles alternate between read slots and write slots. In a read slot the bus carries a read address, and in a write slot it carries a write address. Every address names a burst of four words. Each data port moves two words per cycle, which stands for data on both halves of the clock, so a burst takes two cycles on either port.

A read captured in a read slot returns its four words three and four cycles later. The array is read into a burst holding register one cycle after capture. The first two words sit in an output register for one cycle, and the last two follow in the next. A write keeps its address until both word pairs have arrived, then writes all four words into the array in one commit. When a read asks for the address that such a write is still assembling, a per-word bypass hands it the new data. An echo strobe toggles every cycle, in phase with the output pair, and marks which half of a burst is on the read bus.

Top module: `qdrBurstSram`

## Requirements
- R1: The first cycle after reset is released is a read slot, and slots then alternate read, write, read. `addr` is taken as a read address only in read slots and as a write address only in write slots.
- R2: `rdSelN` and `wrSelN` are active low. `rdSelN` low in a write slot and `wrSelN` low in a read slot have no effect: nothing is read and the array is not changed.
- R3: A lone read captured in cycle t drives `rdValid` high in cycles t+3 and t+4 only.
- R4: Read words come out in burst order. Cycle t+3 carries words 0 and 1, and cycle t+4 carries words 2 and 3. In each pair the earlier word is in `rdData[WORD_W-1:0]`.
- R5: For a write captured in cycle t, `wrData` carries words 0 and 1 in cycle t+1 and words 2 and 3 in cycle t+2, with the earlier word in the low bits. The whole burst is committed at the end of cycle t+2.
- R6: A read returns the burst most recently committed to its address.
- R7: A read captured in the read slot right after the write slot that captured a write to the same address returns that write's four words, even though the commit lands at the same edge as the array lookup.
- R8: A write captured after a read, to the same address, does not change the data that read returns.
- R9: `rdData` is all zero in every cycle in which `rdValid` is low.
- R10: `echoStrobe` is low in read slots and high in write slots. It toggles every cycle after reset, so it is high exactly when valid read data shows words 0 and 1.
- R11: Reset drives `rdValid`, `rdData` and `echoStrobe` low and drops reads and writes that are in flight. Array contents survive reset.
- R12: Reads captured in consecutive read slots give an unbroken run of `rdValid`, with no idle cycle between bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of pipeline state |
| rdSelN | input | 1 | Active-low read select, sampled in read slots |
| wrSelN | input | 1 | Active-low write select, sampled in write slots |
| addr | input | $clog2(DEPTH) | Shared burst address, read or write by slot |
| wrData | input | 2*WORD_W | Two write words per cycle, earlier word low |
| rdData | output | 2*WORD_W | Two read words per cycle, earlier word low |
| rdValid | output | 1 | High while `rdData` carries burst data |
| echoStrobe | output | 1 | Phase strobe, high in write slots and on words 0 and 1 |

## Verification
The edge that ends a write slot does two things at once. It commits the burst that a write has finished assembling, and it takes the array snapshot for the read captured in the slot just before. The stimulus table sets this up by putting a write to one address in a write slot and a read of that same address in the very next read slot. The bench checks that the read returns the new words rather than the old contents. A second case puts a write to an address in the write slot right after a read of that address, and the bench checks that the read still returns the old data. Both results are compared word pair by word pair against values the bench computes, along with the slot phase shown on the echo strobe.

// File: rtl/qdrPkg.sv
package qdrPkg;
  // Strobes from the control sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic loadLo;  // capture first write word pair
    logic commit;  // write the assembled burst into the array
    logic snap;    // load the read burst holding register
    logic fwdHit;  // pending write matches the read address
    logic outHi;   // present words 2,3 instead of words 0,1
    logic outEn;   // holding register carries a live burst
  } ctrlStrobe_t;
endpackage

// File: rtl/qdrCtrl.sv
module qdrCtrl import qdrPkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdSelN,
  input  logic          wrSelN,
  input  logic [AW-1:0] addr,
  output ctrlStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] snapAddr,
  output logic          rdValid,
  output logic          echoStrobe
);
  logic          rdSlotQ;   // current cycle is a read slot
  logic          capActQ;   // read captured in the last read slot
  logic [AW-1:0] capAddrQ;
  logic          holdActQ;  // holding register owns a burst
  logic          wrActQ;    // write address held, data arriving
  logic [AW-1:0] wrAddrQ;
  logic          rdValidQ;
  logic          echoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSlotQ  <= 1'b1;
      capActQ  <= 1'b0;
      capAddrQ <= '0;
      holdActQ <= 1'b0;
      wrActQ   <= 1'b0;
      wrAddrQ  <= '0;
      rdValidQ <= 1'b0;
      echoQ    <= 1'b0;
    end else begin
      rdSlotQ  <= !rdSlotQ;
      echoQ    <= rdSlotQ;
      rdValidQ <= holdActQ;
      if (rdSlotQ) begin
        capActQ <= !rdSelN;
        if (!rdSelN) capAddrQ <= addr;
      end else begin
        holdActQ <= capActQ;
        wrActQ   <= !wrSelN;
        if (!wrSelN) wrAddrQ <= addr;
      end
    end
  end

  always_comb begin
    strobe.loadLo = rdSlotQ && wrActQ;
    strobe.commit = !rdSlotQ && wrActQ;
    strobe.snap   = !rdSlotQ && capActQ;
    strobe.fwdHit = wrActQ && (wrAddrQ == capAddrQ);
    strobe.outHi  = !rdSlotQ;
    strobe.outEn  = holdActQ;
  end

  assign wrAddr     = wrAddrQ;
  assign snapAddr   = capAddrQ;
  assign rdValid    = rdValidQ;
  assign echoStrobe = echoQ;
endmodule

// File: rtl/qdrDatapath.sv
module qdrDatapath import qdrPkg::*; #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 64,
  parameter int AW     = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [AW-1:0]       wrAddr,
  input  logic [AW-1:0]       snapAddr,
  input  logic [2*WORD_W-1:0] wrData,
  output logic [2*WORD_W-1:0] rdData
);
  localparam int PAIR_W  = 2 * WORD_W;
  localparam int BURST_W = 4 * WORD_W;
  localparam int WORDS   = 4;

  logic [BURST_W-1:0] mem [DEPTH];
  logic [PAIR_W-1:0]  wrLoQ;
  logic [BURST_W-1:0] holdQ;
  logic [PAIR_W-1:0]  rdDataQ;
  logic [BURST_W-1:0] incoming;
  logic [BURST_W-1:0] memRd;
  logic [BURST_W-1:0] snapData;

  assign incoming = {wrData, wrLoQ};
  assign memRd    = mem[snapAddr];

  // Per-word bypass from the burst being committed at this edge.
  for (genvar w = 0; w < WORDS; w++) begin : gFwd
    assign snapData[w*WORD_W +: WORD_W] =
      strobe.fwdHit ? incoming[w*WORD_W +: WORD_W] : memRd[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) mem[wrAddr] <= incoming;
    if (strobe.loadLo) wrLoQ <= wrData;
    if (strobe.snap)   holdQ <= snapData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdDataQ <= '0;
    else if (!strobe.outEn) rdDataQ <= '0;
    else if (strobe.outHi)  rdDataQ <= holdQ[BURST_W-1:PAIR_W];
    else                    rdDataQ <= holdQ[PAIR_W-1:0];
  end

  assign rdData = rdDataQ;
endmodule

// File: rtl/qdrBurstSram.sv
module qdrBurstSram import qdrPkg::*; #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdSelN,
  input  logic                wrSelN,
  input  logic [AW-1:0]       addr,
  input  logic [2*WORD_W-1:0] wrData,
  output logic [2*WORD_W-1:0] rdData,
  output logic                rdValid,
  output logic                echoStrobe
);
  ctrlStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] snapAddr;

  qdrCtrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .strobe(strobe), .wrAddr(wrAddr), .snapAddr(snapAddr),
    .rdValid(rdValid), .echoStrobe(echoStrobe)
  );

  qdrDatapath #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .snapAddr(snapAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/qdrBurstSramChk.sv
module qdrBurstSramChk #(
  parameter int WORD_W = 18
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdSelN,
  input logic [2*WORD_W-1:0] rdData,
  input logic                rdValid,
  input logic                echoStrobe
);
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R3: a read accepted in a read slot shows valid three edges later
  assert_rd_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!echoStrobe && !rdSelN) |-> ##3 rdValid);

  // R3: words 2,3 always follow words 0,1
  assert_valid_pair_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && echoStrobe) |=> rdValid);

  // R2: valid first pair only when a read was accepted in a read slot
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && echoStrobe) |-> $past(!rdSelN && !echoStrobe, 3));

  // R10: echo strobe toggles every cycle once running
  assert_echo_toggle_R10: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (echoStrobe != $past(echoStrobe)));

  // R9: idle read bus is zero
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R11: outputs quiet after a reset cycle
  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rstN |=> (!rdValid && !echoStrobe));
endmodule

bind qdrBurstSram qdrBurstSramChk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .rdData(rdData),
  .rdValid(rdValid), .echoStrobe(echoStrobe)
);

// File: tb/sim_qdrBurstSram.sv
module sim_qdrBurstSram;
  localparam int W  = 18;
  localparam int AW = 6;
  localparam int PW = 2 * W;
  localparam int ROWS = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdSelN = 1'b1;
  logic          wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [PW-1:0] wrData = '0;
  logic [PW-1:0] rdData;
  logic          rdValid;
  logic          echoStrobe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdrBurstSram u0 (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .echoStrobe(echoStrobe)
  );

  // Word pairs {later, earlier}
  localparam logic [PW-1:0] P_BA = {18'h000B2, 18'h000A1};
  localparam logic [PW-1:0] P_DC = {18'h000D4, 18'h000C3};
  localparam logic [PW-1:0] P_FE = {18'h010F6, 18'h010E5};
  localparam logic [PW-1:0] P_HG = {18'h02118, 18'h02107};
  localparam logic [PW-1:0] P_JI = {18'h0313A, 18'h03129};
  localparam logic [PW-1:0] P_LK = {18'h0015C, 18'h0014B};
  localparam logic [PW-1:0] P_XX = {18'h3FFFF, 18'h3FFFF};

  typedef struct packed {
    logic          rs;
    logic          ws;
    logic [AW-1:0] ad;
    logic [PW-1:0] wd;
    logic          ev;
    logic [PW-1:0] ed;
  } vec_t;

  // Even rows are read slots, odd rows write slots (R1).
  localparam vec_t VEC [ROWS] = '{
    '{1'b1, 1'b1, 6'd0, '0,   1'b0, '0},    // 0 idle
    '{1'b1, 1'b0, 6'd5, '0,   1'b0, '0},    // 1 write 5 captured
    '{1'b1, 1'b1, 6'd0, P_BA, 1'b0, '0},    // 2 words 0,1 of write 5
    '{1'b1, 1'b0, 6'd9, P_DC, 1'b0, '0},    // 3 words 2,3; write 9 captured
    '{1'b0, 1'b1, 6'd9, P_FE, 1'b0, '0},    // 4 read 9 while in flight (R7)
    '{1'b0, 1'b1, 6'd7, P_HG, 1'b0, '0},    // 5 read select in write slot (R2)
    '{1'b0, 1'b1, 6'd5, '0,   1'b0, '0},    // 6 read 5
    '{1'b1, 1'b0, 6'd5, '0,   1'b1, P_FE},  // 7 write 5 after read (R8)
    '{1'b1, 1'b0, 6'd9, P_JI, 1'b1, P_HG},  // 8 write select in read slot (R2)
    '{1'b1, 1'b1, 6'd0, P_LK, 1'b1, P_BA},  // 9
    '{1'b0, 1'b1, 6'd5, P_XX, 1'b1, P_DC},  // 10 read 5 again (R6)
    '{1'b1, 1'b1, 6'd0, '0,   1'b0, '0},    // 11
    '{1'b0, 1'b1, 6'd9, '0,   1'b0, '0},    // 12 read 9, must be intact
    '{1'b1, 1'b1, 6'd0, '0,   1'b1, P_JI},  // 13
    '{1'b1, 1'b1, 6'd0, '0,   1'b1, P_LK},  // 14
    '{1'b1, 1'b1, 6'd0, '0,   1'b1, P_FE},  // 15
    '{1'b1, 1'b1, 6'd0, '0,   1'b1, P_HG},  // 16
    '{1'b1, 1'b1, 6'd0, '0,   1'b0, '0}     // 17
  };

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rs, input logic ws, input logic [AW-1:0] ad,
                       input logic [PW-1:0] wd);
    rdSelN = rs; wrSelN = ws; addr = ad; wrData = wd;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 rdValid in reset", PW'(rdValid), '0);
    check("R11 rdData in reset", rdData, '0);
    check("R11 echoStrobe in reset", PW'(echoStrobe), '0);
    rstN = 1'b1;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
    for (int i = 0; i < ROWS; i++) begin
      check($sformatf("R3/R12 rdValid row %0d", i), PW'(rdValid), PW'(VEC[i].ev));
      check($sformatf("R4/R5/R6/R7/R8/R9/R2 rdData row %0d", i), rdData, VEC[i].ed);
      check($sformatf("R1/R10 echoStrobe row %0d", i), PW'(echoStrobe), PW'(i % 2));
      drive(VEC[i].rs, VEC[i].ws, VEC[i].ad, VEC[i].wd);
    end

    // R11: read in flight, then reset; array must keep address 5 = {L,K,J,I}
    drive(1'b0, 1'b1, 6'd5, '0);
    rstN = 1'b0;
    drive(1'b1, 1'b1, 6'd0, '0);
    drive(1'b1, 1'b1, 6'd0, '0);
    check("R11 rdValid mid reset", PW'(rdValid), '0);
    check("R11 rdData mid reset", rdData, '0);
    rstN = 1'b1;
    // R1: first cycle after release is a read slot
    check("R1/R10 echoStrobe after release", PW'(echoStrobe), '0);
    drive(1'b0, 1'b1, 6'd5, '0);
    for (int k = 1; k <= 2; k++) begin
      check($sformatf("R11 dropped read, row %0d", k), PW'(rdValid), '0);
      drive(1'b1, 1'b1, 6'd0, '0);
    end
    check("R11/R3 rdValid words 0,1", PW'(rdValid), PW'(1));
    check("R11/R6 array kept words 0,1", rdData, P_JI);
    drive(1'b1, 1'b1, 6'd0, '0);
    check("R11/R4 array kept words 2,3", rdData, P_LK);
    drive(1'b1, 1'b1, 6'd0, '0);
    check("R3 rdValid ends after burst", PW'(rdValid), '0);
    check("R9 rdData idle", rdData, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule